// File: doc/BRIEF.md
# Binary/Decimal Add-Subtract Unit

This block adds two operands with an incoming carry, or subtracts one from the other with an incoming borrow. The operands are either plain binary or packed BCD. Each 4-bit digit lane makes a binary nibble sum and then, in decimal mode, corrects that sum back into the 0..9 range. The lanes are chained through their carries, so the same adder serves both number systems.

In binary mode the unit reports carry, zero, overflow and negative. In decimal mode only the carry is meaningful. The zero, overflow and negative outputs are forced low, and a flag-valid output goes low to mark them as not usable.

A parameter picks between a purely combinational path and a single output register. The default build has the register.

Top module: `bcd_addsub_unit`

## Requirements
- R1: With `dec_i`=0 and `sub_i`=0, `res_o` = (`a_i` + `b_i` + `cin_i`) mod 256, and `c_o` is the carry out of bit 7.
- R2: With `dec_i`=0 and `sub_i`=1, `res_o` = (`a_i` - `b_i` - (1 - `cin_i`)) mod 256. `cin_i`=1 means no incoming borrow. `c_o`=1 exactly when no borrow occurred, that is when `a_i` >= `b_i` + (1 - `cin_i`).
- R3: In binary mode, `v_o`=1 exactly when the result of the operation, read as signed two's complement, lies outside -128..+127. It can never be set when the two effective addends differ in sign.
- R4: In binary mode, `z_o`=1 exactly when `res_o` is 0, and `n_o` equals `res_o` bit 7.
- R5: With `dec_i`=1 and `sub_i`=0, and both operands valid packed BCD (high digit in bits 7:4, low digit in bits 3:0), `res_o` is the BCD encoding of (A + B + `cin_i`) mod 100. `c_o`=1 exactly when that sum exceeds 99.
- R6: With `dec_i`=1 and `sub_i`=1, `res_o` is the BCD encoding of (A - B - (1 - `cin_i`)) mod 100. `c_o`=0 exactly when that difference is negative.
- R7: `flags_ok_o` is 1 in binary mode and 0 in decimal mode. In decimal mode `z_o`, `v_o` and `n_o` are all 0.
- R8: With OUT_REG=1 (the default), the outputs reflect the inputs present at the previous rising clock edge and do not change between edges. With OUT_REG=0 they follow the inputs combinationally.
- R9: A synchronous active-high `rst` clears `res_o` and all flag outputs, including `flags_ok_o`, to 0 at the next rising edge.
- R10: In decimal addition, a digit whose binary nibble sum reaches 16 or more (for example 9+9+1 = 19) is corrected to the right digit and carries into the next digit. In decimal subtraction, a borrow ripples through zero digits (00 - 01 gives 99 with `c_o`=0).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst | input | 1 | Synchronous active-high reset |
| a_i | input | 8 | First operand (minuend in subtraction) |
| b_i | input | 8 | Second operand (subtrahend in subtraction) |
| cin_i | input | 1 | Carry in; for subtraction, 1 means no borrow |
| sub_i | input | 1 | 0 = add with carry, 1 = subtract with borrow |
| dec_i | input | 1 | 0 = binary, 1 = packed-BCD arithmetic |
| res_o | output | 8 | Result |
| c_o | output | 1 | Carry out, or not-borrow for subtraction |
| z_o | output | 1 | Result-is-zero flag (binary mode only) |
| v_o | output | 1 | Signed overflow flag (binary mode only) |
| n_o | output | 1 | Negative flag (binary mode only) |
| flags_ok_o | output | 1 | 1 when z_o, v_o and n_o are meaningful |

## Verification
The hardest cases to reach are the decimal corrections that depend on a nibble carry rather than on the digit value. The low digit's binary sum has to wrap past 15, as in 09+09 with carry-in, and a borrow has to travel through a zero high digit, as in 00-01. Directed operand pairs are chosen to land on exactly these sums. A strided sweep over valid BCD pairs, run in both add and subtract, then catches any digit position that is corrected wrongly. The bench compares every result against decimal integer arithmetic.

// File: rtl/bcd_addsub_pkg.sv
package bcd_addsub_pkg;

    localparam int NIB = 4;
    localparam logic [NIB-1:0] DIGIT_MAX = 4'd9;
    localparam logic [NIB:0]   DEC_FIX   = 5'd6;

    typedef enum logic {
        OP_ADD = 1'b0,
        OP_SUB = 1'b1
    } op_e;

    typedef enum logic {
        MODE_BIN = 1'b0,
        MODE_DEC = 1'b1
    } mode_e;

    typedef struct packed {
        logic c;
        logic z;
        logic v;
        logic n;
        logic ok;
    } flags_t;

    // Effective second addend for one nibble: inverted for subtraction.
    function automatic logic [NIB-1:0] eff_operand(input logic [NIB-1:0] b, input op_e op);
        return (op == OP_SUB) ? ~b : b;
    endfunction

endpackage

// File: rtl/bcd_digit_cell.sv
module bcd_digit_cell
    import bcd_addsub_pkg::*;
(
    input  logic [NIB-1:0] a_i,
    input  logic [NIB-1:0] b_i,
    input  logic           cin_i,
    input  op_e            op_i,
    input  mode_e          mode_i,
    output logic [NIB-1:0] sum_o,
    output logic           cout_o
);

    logic [NIB:0] raw;
    logic [NIB:0] fixed;
    logic         need_fix;

    always_comb begin
        raw      = {1'b0, a_i} + {1'b0, eff_operand(b_i, op_i)} + {{NIB{1'b0}}, cin_i};
        fixed    = raw;
        need_fix = 1'b0;
        if (mode_i == MODE_DEC) begin
            if (op_i == OP_ADD) begin
                need_fix = raw[NIB] || (raw[NIB-1:0] > DIGIT_MAX);
                if (need_fix) fixed = raw + DEC_FIX;
            end else begin
                need_fix = !raw[NIB];
                if (need_fix) fixed = raw - DEC_FIX;
            end
        end
    end

    always_comb begin
        sum_o = fixed[NIB-1:0];
        if (mode_i == MODE_DEC)
            cout_o = (op_i == OP_ADD) ? need_fix : !need_fix;
        else
            cout_o = raw[NIB];
    end

    // R5/R6: valid BCD digits in decimal mode must produce a valid digit
    always_comb begin
        if (mode_i == MODE_DEC && a_i <= DIGIT_MAX && b_i <= DIGIT_MAX) begin
            p_digit_range_r5: assert (sum_o <= DIGIT_MAX)
                else $error("decimal digit out of range");
        end
    end

endmodule

// File: rtl/bcd_addsub_core.sv
module bcd_addsub_core
    import bcd_addsub_pkg::*;
#(
    parameter int DIGITS = 2,
    localparam int W = DIGITS * NIB
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         cin_i,
    input  op_e          op_i,
    input  mode_e        mode_i,
    output logic [W-1:0] res_o,
    output flags_t       flags_o
);

    logic [DIGITS:0] chain;
    assign chain[0] = cin_i;

    for (genvar g = 0; g < DIGITS; g++) begin : g_digit
        bcd_digit_cell u_cell (
            .a_i    (a_i[g*NIB +: NIB]),
            .b_i    (b_i[g*NIB +: NIB]),
            .cin_i  (chain[g]),
            .op_i   (op_i),
            .mode_i (mode_i),
            .sum_o  (res_o[g*NIB +: NIB]),
            .cout_o (chain[g+1])
        );
    end

    logic a_msb, b_msb;
    assign a_msb = a_i[W-1];
    assign b_msb = (op_i == OP_SUB) ? !b_i[W-1] : b_i[W-1];

    always_comb begin
        flags_o.c  = chain[DIGITS];
        flags_o.ok = (mode_i == MODE_BIN);
        if (mode_i == MODE_BIN) begin
            flags_o.z = (res_o == '0);
            flags_o.n = res_o[W-1];
            flags_o.v = (a_msb == b_msb) && (res_o[W-1] != a_msb);
        end else begin
            flags_o.z = 1'b0;
            flags_o.n = 1'b0;
            flags_o.v = 1'b0;
        end
    end

    // R3: addends of opposite sign can never overflow
    always_comb begin
        if (mode_i == MODE_BIN && a_i[W-1] != (b_i[W-1] ^ (op_i == OP_SUB))) begin
            p_no_overflow_r3: assert (!flags_o.v)
                else $error("overflow with mixed-sign addends");
        end
    end

endmodule

// File: rtl/bcd_addsub_unit.sv
module bcd_addsub_unit
    import bcd_addsub_pkg::*;
#(
    parameter int DIGITS  = 2,
    parameter bit OUT_REG = 1'b1,
    localparam int W = DIGITS * NIB
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         cin_i,
    input  logic         sub_i,
    input  logic         dec_i,
    output logic [W-1:0] res_o,
    output logic         c_o,
    output logic         z_o,
    output logic         v_o,
    output logic         n_o,
    output logic         flags_ok_o
);

    logic [W-1:0] comb_res;
    flags_t       comb_flags;
    logic [W-1:0] out_res;
    flags_t       out_flags;

    bcd_addsub_core #(.DIGITS(DIGITS)) u_core (
        .a_i     (a_i),
        .b_i     (b_i),
        .cin_i   (cin_i),
        .op_i    (op_e'(sub_i)),
        .mode_i  (mode_e'(dec_i)),
        .res_o   (comb_res),
        .flags_o (comb_flags)
    );

    if (OUT_REG) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst) begin
                out_res   <= '0;
                out_flags <= '0;
            end else begin
                out_res   <= comb_res;
                out_flags <= comb_flags;
            end
        end

        // R7/R8: validity follows the mode seen one edge earlier
        p_valid_follows_mode_r7: assert property (@(posedge clk) disable iff (rst)
            1'b1 |=> (flags_ok_o == !$past(dec_i)));

        // R8: outputs capture the result computed before the edge
        p_latency_r8: assert property (@(posedge clk) disable iff (rst)
            1'b1 |=> (res_o == $past(comb_res)));
    end else begin : g_comb
        assign out_res   = comb_res;
        assign out_flags = comb_flags;
    end

    assign res_o      = out_res;
    assign c_o        = out_flags.c;
    assign z_o        = out_flags.z;
    assign v_o        = out_flags.v;
    assign n_o        = out_flags.n;
    assign flags_ok_o = out_flags.ok;

    p_zero_r4: assert property (@(posedge clk) disable iff (rst)
        flags_ok_o |-> (z_o == (res_o == '0)));

    p_negative_r4: assert property (@(posedge clk) disable iff (rst)
        flags_ok_o |-> (n_o == res_o[W-1]));

    p_dec_flags_low_r7: assert property (@(posedge clk) disable iff (rst)
        !flags_ok_o |-> (!z_o && !v_o && !n_o));

endmodule

// File: tb/tb_bcd_addsub_unit.sv
module tb_bcd_addsub_unit;

    logic       clk = 1'b0;
    logic       rst;
    logic [7:0] a, b;
    logic       cin, sub, dec;
    logic [7:0] res;
    logic       c, z, v, n, ok;

    int checks   = 0;
    int failures = 0;
    bit done     = 0;

    always #5 clk = ~clk;

    bcd_addsub_unit dut (
        .clk(clk), .rst(rst), .a_i(a), .b_i(b), .cin_i(cin), .sub_i(sub),
        .dec_i(dec), .res_o(res), .c_o(c), .z_o(z), .v_o(v), .n_o(n),
        .flags_ok_o(ok)
    );

    function automatic int from_bcd(input logic [7:0] x);
        return int'(x[7:4]) * 10 + int'(x[3:0]);
    endfunction

    function automatic logic [7:0] to_bcd(input int x);
        return {4'(x / 10), 4'(x % 10)};
    endfunction

    // Expected output bundle {res, c, z, v, n, ok}
    function automatic logic [12:0] model(input logic [7:0] ea, input logic [7:0] eb,
                                          input logic ec, input logic es, input logic ed);
        logic [7:0] r;
        logic cc, zz, vv, nn;
        int s;
        if (ed) begin
            if (!es) begin
                s = from_bcd(ea) + from_bcd(eb) + int'(ec);
                cc = (s > 99);
                r = to_bcd(s % 100);
            end else begin
                s = from_bcd(ea) - from_bcd(eb) - (1 - int'(ec));
                cc = (s >= 0);
                r = to_bcd((s + 100) % 100);
            end
            return {r, cc, 1'b0, 1'b0, 1'b0, 1'b0};
        end
        if (!es) begin
            s = int'(ea) + int'(eb) + int'(ec);
            cc = (s > 255);
            vv = ((int'($signed(ea)) + int'($signed(eb)) + int'(ec)) > 127) ||
                 ((int'($signed(ea)) + int'($signed(eb)) + int'(ec)) < -128);
        end else begin
            s = int'(ea) - int'(eb) - (1 - int'(ec));
            cc = (s >= 0);
            vv = ((int'($signed(ea)) - int'($signed(eb)) - (1 - int'(ec))) > 127) ||
                 ((int'($signed(ea)) - int'($signed(eb)) - (1 - int'(ec))) < -128);
        end
        r  = s[7:0];
        zz = (r == 8'h00);
        nn = r[7];
        return {r, cc, zz, vv, nn, 1'b1};
    endfunction

    task automatic compare(input string req, input logic [12:0] exp_v);
        checks++;
        if ({res, c, z, v, n, ok} !== exp_v) begin
            failures++;
            $display("FAIL %s a=%h b=%h cin=%b sub=%b dec=%b actual res=%h c=%b z=%b v=%b n=%b ok=%b expected res=%h c=%b z=%b v=%b n=%b ok=%b",
                     req, a, b, cin, sub, dec, res, c, z, v, n, ok,
                     exp_v[12:5], exp_v[4], exp_v[3], exp_v[2], exp_v[1], exp_v[0]);
        end
    endtask

    // Drive at negedge, result registered at next posedge, sample at next negedge
    task automatic run(input string req, input logic [7:0] ta, input logic [7:0] tb,
                       input logic tc, input logic ts, input logic td);
        a = ta; b = tb; cin = tc; sub = ts; dec = td;
        @(negedge clk);
        compare(req, model(ta, tb, tc, ts, td));
    endtask

    task automatic t_reset;
        rst = 1'b1;
        a = 8'hFF; b = 8'hFF; cin = 1'b1; sub = 1'b0; dec = 1'b0;
        repeat (3) @(negedge clk);
        compare("R9 reset", 13'h0);
        rst = 1'b0;
    endtask

    task automatic t_bin_add;
        run("R1 add", 8'h12, 8'h34, 1'b0, 1'b0, 1'b0);
        run("R1 add carry-in", 8'h0F, 8'h01, 1'b1, 1'b0, 1'b0);
        run("R1 add carry-out", 8'hF0, 8'h20, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic t_bin_sub;
        run("R2 sub no borrow", 8'h50, 8'h20, 1'b1, 1'b1, 1'b0);
        run("R2 sub borrow-in", 8'h50, 8'h50, 1'b0, 1'b1, 1'b0);
        run("R2 sub borrow-out", 8'h10, 8'h20, 1'b1, 1'b1, 1'b0);
    endtask

    task automatic t_overflow;
        run("R3 pos+pos overflow", 8'h7F, 8'h01, 1'b0, 1'b0, 1'b0);
        run("R3 neg+neg overflow", 8'h80, 8'hFF, 1'b0, 1'b0, 1'b0);
        run("R3 mixed sign no overflow", 8'h7F, 8'h80, 1'b1, 1'b0, 1'b0);
        run("R3 sub overflow", 8'h80, 8'h01, 1'b1, 1'b1, 1'b0);
    endtask

    task automatic t_zero_neg;
        run("R4 zero", 8'hFF, 8'h01, 1'b0, 1'b0, 1'b0);
        run("R4 negative", 8'h00, 8'h01, 1'b1, 1'b1, 1'b0);
    endtask

    task automatic t_dec_add;
        run("R5 dec add", 8'h25, 8'h48, 1'b0, 1'b0, 1'b1);
        run("R5 dec add carry", 8'h99, 8'h01, 1'b0, 1'b0, 1'b1);
        run("R10 dec add nibble wrap", 8'h09, 8'h09, 1'b1, 1'b0, 1'b1);
        run("R10 dec add both wrap", 8'h99, 8'h99, 1'b1, 1'b0, 1'b1);
    endtask

    task automatic t_dec_sub;
        run("R6 dec sub", 8'h42, 8'h17, 1'b1, 1'b1, 1'b1);
        run("R6 dec sub borrow-in", 8'h50, 8'h50, 1'b0, 1'b1, 1'b1);
        run("R10 dec sub ripple", 8'h00, 8'h01, 1'b1, 1'b1, 1'b1);
    endtask

    task automatic t_dec_flags;
        // zero result in decimal mode: z_o stays 0, flags_ok_o 0
        run("R7 dec zero result", 8'h50, 8'h50, 1'b1, 1'b1, 1'b1);
        run("R7 back to binary", 8'h50, 8'h50, 1'b1, 1'b1, 1'b0);
    endtask

    task automatic t_latency;
        logic [12:0] held;
        run("R8 setup", 8'h11, 8'h22, 1'b0, 1'b0, 1'b0);
        held = model(8'h11, 8'h22, 1'b0, 1'b0, 1'b0);
        a = 8'h80; b = 8'h80; cin = 1'b0; sub = 1'b0; dec = 1'b0;
        #2;
        compare("R8 hold before edge", held);
        @(negedge clk);
        compare("R8 update after edge", model(8'h80, 8'h80, 1'b0, 1'b0, 1'b0));
    endtask

    task automatic t_sweep;
        for (int i = 0; i < 100; i += 7) begin
            for (int j = 0; j < 100; j += 11) begin
                run("R5 sweep", to_bcd(i), to_bcd(j), 1'(j & 1), 1'b0, 1'b1);
                run("R6 sweep", to_bcd(i), to_bcd(j), 1'(i & 1), 1'b1, 1'b1);
            end
        end
    endtask

    initial begin
        a = '0; b = '0; cin = 0; sub = 0; dec = 0; rst = 1'b1;
        @(negedge clk);
        t_reset();
        t_bin_add();
        t_bin_sub();
        t_overflow();
        t_zero_neg();
        t_dec_add();
        t_dec_sub();
        t_dec_flags();
        t_latency();
        t_sweep();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule